// File: doc/BRIEF.md
# Program Suspend and Resume Controller

This block wraps a flash program engine, modelled as a count of busy cycles, and lets the host pause and continue a program operation. The host issues commands as data words on a write stream. A suspend code stops the engine from the cycle it is accepted. The block then waits a fixed settling time before it reports the program as held. A resume code restarts the engine, and the engine carries on with the cycles it still had left.

While a program is held, or while no program runs, the host may read the array or the identification codes. Reads aimed at the sector being programmed, or at a sector whose erase has been put on hold by a neighbouring block, do not return array data. They return the status byte instead.

The command stream has `cmd_ready` tied high: every word is taken and words that mean nothing in the current phase are dropped. The read request stream applies back-pressure. `rd_ready` is low while the engine runs or settles, and the host must hold `rd_valid` and `rd_addr` steady until a cycle where both are high. The response stream has no back-pressure. `rsp_valid` lasts one cycle and the host must take it then.

Top module: `pgm_suspend_ctrl`

## Requirements
- R1: After reset the block is idle. `pgm_busy`, `pgm_held` and `status_byte` are 0, and `rd_ready` and `cmd_ready` are 1.
- R2: A `pgm_start` accepted while idle with a nonzero `pgm_len` L makes `eng_run` high for L cycles in total. `pgm_done` pulses for one cycle, in the cycle after the last `eng_run` cycle. A start with L equal to 0 is dropped.
- R3: A command word 0xB0 accepted while the engine runs lowers `eng_run` in that same cycle. `pgm_busy` stays high for SETTLE_CYC cycles after the accepting edge. `pgm_held` then rises and `pgm_busy` falls.
- R4: A command word 0x30 accepted while held restarts the engine. The engine continues with the remaining count, so across any number of suspends the total count of `eng_run` cycles equals L.
- R5: A read accepted while held returns `status_byte` if its sector field (`rd_addr` upper SECT_W bits) equals the held program's sector. Any other sector returns `arr_rdata` for the requested address.
- R6: A read with `rd_asel` set returns MFR_ID when the offset field (lower OFS_W bits) is zero and DEV_ID otherwise, whatever the sector.
- R7: When `es_active` is high, reads of sector `es_sect` return `status_byte`. A program started while `es_active` is high sets status bit 2 until that program completes.
- R8: `status_byte` encodes bit 0 = busy (running or settling), bit 1 = held, bit 2 = program nested in an erase hold, other bits 0. Command words 0xB0 outside the running phase, 0x30 outside the held phase, and any other word change nothing.
- R9: `rd_ready` is high only when idle or held. `rsp_valid` rises exactly one cycle after each `rd_valid`/`rd_ready` handshake.
- R10: Asserting `rst_n` low at any time, including while held, returns the block at once to the idle state of R1.
- R11: `pgm_start` is ignored unless the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_data | input | DATA_W | Command word |
| pgm_start | input | 1 | Start a program operation |
| pgm_len | input | LEN_W | Engine busy cycles for the program |
| pgm_sect | input | SECT_W | Sector being programmed |
| eng_run | output | 1 | Engine advances one count this cycle |
| pgm_done | output | 1 | One-cycle completion pulse |
| es_active | input | 1 | An erase is on hold elsewhere |
| es_sect | input | SECT_W | Sector of the held erase |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted |
| rd_addr | input | SECT_W+OFS_W | Read address, sector in upper bits |
| rd_asel | input | 1 | Request identification code |
| arr_addr | output | SECT_W+OFS_W | Array read address |
| arr_rdata | input | DATA_W | Array read data (combinational) |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DATA_W | Read response data |
| pgm_busy | output | 1 | Running or settling |
| pgm_held | output | 1 | Program suspended |
| status_byte | output | DATA_W | Status word |

## Verification
`eng_run` and `rd_ready` react in the cycle of their stimulus. `pgm_done` follows the last run cycle by one edge. `pgm_held` follows the accepting edge of a suspend by SETTLE_CYC edges, and a read response follows its handshake by one edge. Reset acts without waiting for an edge. A behavioural model in the bench steps on each rising edge. The bench compares every output with the model a quarter period before the next edge, when inputs and registered outputs are both stable. Directed checks then count run cycles and sample held-state reads at the cycle where each result is due.

// File: rtl/pgm_susp_pkg.sv
package pgm_susp_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_RUN    = 2'd1,
    PS_SETTLE = 2'd2,
    PS_HELD   = 2'd3
  } pstate_t;

  localparam logic [7:0] CODE_SUSPEND = 8'hB0;
  localparam logic [7:0] CODE_RESUME  = 8'h30;
endpackage

// File: rtl/pgm_cmd_decode.sv
module pgm_cmd_decode #(
  parameter int DATA_W = 8
) (
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              sus_req,
  output logic              res_req
);
  import pgm_susp_pkg::*;

  // Address is a don't-care upstream; only the data word selects the action.
  assign sus_req = cmd_valid && (cmd_data == DATA_W'(CODE_SUSPEND));
  assign res_req = cmd_valid && (cmd_data == DATA_W'(CODE_RESUME));
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq #(
  parameter int LEN_W      = 16,
  parameter int SECT_W     = 4,
  parameter int SETTLE_CYC = 750
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LEN_W-1:0]      start_len,
  input  logic [SECT_W-1:0]     start_sect,
  input  logic                  es_active,
  input  logic                  sus_req,
  input  logic                  res_req,
  output pgm_susp_pkg::pstate_t state,
  output logic                  eng_run,
  output logic                  done,
  output logic [SECT_W-1:0]     held_sect,
  output logic                  in_es
);
  import pgm_susp_pkg::*;

  localparam int LAT_W = $clog2(SETTLE_CYC + 1);

  pstate_t          st;
  logic [LEN_W-1:0] rem;
  logic [LAT_W-1:0] lat;

  // Suspend wins over the count in the cycle it arrives.
  assign eng_run   = (st == PS_RUN) && !sus_req;
  assign state     = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_IDLE;
      rem       <= '0;
      lat       <= '0;
      done      <= 1'b0;
      held_sect <= '0;
      in_es     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        PS_IDLE: begin
          if (start && (start_len != '0)) begin
            st        <= PS_RUN;
            rem       <= start_len;
            held_sect <= start_sect;
            in_es     <= es_active;
          end
        end
        PS_RUN: begin
          if (sus_req) begin
            st  <= PS_SETTLE;
            lat <= LAT_W'(SETTLE_CYC);
          end else begin
            if (rem == LEN_W'(1)) begin
              st    <= PS_IDLE;
              done  <= 1'b1;
              in_es <= 1'b0;
            end
            rem <= rem - LEN_W'(1);
          end
        end
        PS_SETTLE: begin
          if (lat <= LAT_W'(1)) st <= PS_HELD;
          else                  lat <= lat - LAT_W'(1);
        end
        PS_HELD: begin
          if (res_req) st <= PS_RUN;
        end
        default: st <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgm_read_path.sv
module pgm_read_path #(
  parameter int              SECT_W = 4,
  parameter int              OFS_W  = 8,
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_ID = 8'h01,
  parameter logic [DATA_W-1:0] DEV_ID = 8'hA7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      open,
  input  logic                      held,
  input  logic [SECT_W-1:0]         held_sect,
  input  logic                      es_active,
  input  logic [SECT_W-1:0]         es_sect,
  input  logic [DATA_W-1:0]         status,
  input  logic                      rd_valid,
  input  logic [SECT_W+OFS_W-1:0]   rd_addr,
  input  logic                      rd_asel,
  output logic                      rd_ready,
  output logic [SECT_W+OFS_W-1:0]   arr_addr,
  input  logic [DATA_W-1:0]         arr_rdata,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_data
);
  localparam int ADDR_W = SECT_W + OFS_W;

  logic [SECT_W-1:0] sect;
  logic [OFS_W-1:0]  ofs;
  logic              fire;
  logic              blocked;
  logic [DATA_W-1:0] pick;

  assign sect     = rd_addr[ADDR_W-1 -: SECT_W];
  assign ofs      = rd_addr[OFS_W-1:0];
  assign rd_ready = open;
  assign fire     = rd_valid && open;
  assign arr_addr = rd_addr;
  assign blocked  = (held && (sect == held_sect)) || (es_active && (sect == es_sect));

  always_comb begin
    if (rd_asel)      pick = (ofs == '0) ? MFR_ID : DEV_ID;
    else if (blocked) pick = status;
    else              pick = arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) rsp_data <= pick;
    end
  end
endmodule

// File: rtl/pgm_suspend_ctrl.sv
module pgm_suspend_ctrl #(
  parameter int                SECT_W     = 4,
  parameter int                OFS_W      = 8,
  parameter int                DATA_W     = 8,
  parameter int                LEN_W      = 16,
  parameter int                SETTLE_CYC = 750,
  parameter logic [DATA_W-1:0] MFR_ID     = 8'h01,
  parameter logic [DATA_W-1:0] DEV_ID     = 8'hA7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [DATA_W-1:0]       cmd_data,
  input  logic                    pgm_start,
  input  logic [LEN_W-1:0]        pgm_len,
  input  logic [SECT_W-1:0]       pgm_sect,
  output logic                    eng_run,
  output logic                    pgm_done,
  input  logic                    es_active,
  input  logic [SECT_W-1:0]       es_sect,
  input  logic                    rd_valid,
  output logic                    rd_ready,
  input  logic [SECT_W+OFS_W-1:0] rd_addr,
  input  logic                    rd_asel,
  output logic [SECT_W+OFS_W-1:0] arr_addr,
  input  logic [DATA_W-1:0]       arr_rdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    pgm_busy,
  output logic                    pgm_held,
  output logic [DATA_W-1:0]       status_byte
);
  import pgm_susp_pkg::*;

  logic              sus_req, res_req;
  pstate_t           st;
  logic [SECT_W-1:0] held_sect;
  logic              in_es;
  logic              open;

  assign cmd_ready = 1'b1;

  pgm_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .sus_req   (sus_req),
    .res_req   (res_req)
  );

  pgm_seq #(.LEN_W(LEN_W), .SECT_W(SECT_W), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (pgm_start),
    .start_len  (pgm_len),
    .start_sect (pgm_sect),
    .es_active  (es_active),
    .sus_req    (sus_req),
    .res_req    (res_req),
    .state      (st),
    .eng_run    (eng_run),
    .done       (pgm_done),
    .held_sect  (held_sect),
    .in_es      (in_es)
  );

  assign pgm_busy    = (st == PS_RUN) || (st == PS_SETTLE);
  assign pgm_held    = (st == PS_HELD);
  assign open        = (st == PS_IDLE) || (st == PS_HELD);
  assign status_byte = DATA_W'({in_es, pgm_held, pgm_busy});

  pgm_read_path #(
    .SECT_W(SECT_W), .OFS_W(OFS_W), .DATA_W(DATA_W),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .open      (open),
    .held      (pgm_held),
    .held_sect (held_sect),
    .es_active (es_active),
    .es_sect   (es_sect),
    .status    (status_byte),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .rd_asel   (rd_asel),
    .rd_ready  (rd_ready),
    .arr_addr  (arr_addr),
    .arr_rdata (arr_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/pgm_suspend_checker.sv
module pgm_suspend_checker (
  input logic clk,
  input logic rst_n,
  input logic eng_run,
  input logic pgm_done,
  input logic pgm_busy,
  input logic pgm_held,
  input logic rd_valid,
  input logic rd_ready,
  input logic rsp_valid
);
  // R2: completion only follows a cycle of engine progress
  assert_done_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_done |-> $past(eng_run));

  // R3: held state is only reached from the settling phase
  assert_held_from_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_held) |-> $past(pgm_busy));

  // R3: busy and held never overlap
  assert_busy_held_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_busy && pgm_held));

  // R4: remaining count is frozen while held
  assert_frozen_when_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_held |-> !eng_run);

  // R9: reads are refused while running or settling
  assert_no_read_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_busy |-> !rd_ready);

  // R9: response one cycle after handshake
  assert_rsp_next_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);
endmodule

bind pgm_suspend_ctrl pgm_suspend_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eng_run   (eng_run),
  .pgm_done  (pgm_done),
  .pgm_busy  (pgm_busy),
  .pgm_held  (pgm_held),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/pgm_suspend_ctrl_bench.sv
module pgm_suspend_ctrl_bench;
  localparam int LAT = 750;
  localparam logic [7:0] MFR = 8'h01;
  localparam logic [7:0] DEV = 8'hA7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [7:0] cmd_data = 8'h00;
  logic pgm_start = 1'b0;
  logic [15:0] pgm_len = 16'd0;
  logic [3:0] pgm_sect = 4'd0;
  logic eng_run, pgm_done;
  logic es_active = 1'b0;
  logic [3:0] es_sect = 4'd0;
  logic rd_valid = 1'b0;
  logic rd_ready;
  logic [11:0] rd_addr = 12'd0;
  logic rd_asel = 1'b0;
  logic [11:0] arr_addr;
  logic [7:0] arr_rdata;
  logic rsp_valid;
  logic [7:0] rsp_data;
  logic pgm_busy, pgm_held;
  logic [7:0] status_byte;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int run_cnt = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] arr_fn(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], 4'hC};
  endfunction

  assign arr_rdata = arr_fn(arr_addr);

  pgm_suspend_ctrl #(.SETTLE_CYC(LAT), .MFR_ID(MFR), .DEV_ID(DEV)) u_pgm_suspend_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .pgm_start(pgm_start), .pgm_len(pgm_len), .pgm_sect(pgm_sect),
    .eng_run(eng_run), .pgm_done(pgm_done), .es_active(es_active), .es_sect(es_sect),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_asel(rd_asel),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pgm_busy(pgm_busy), .pgm_held(pgm_held), .status_byte(status_byte)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: 0 idle, 1 running, 2 settling, 3 held
  int m_st = 0;
  int m_rem = 0;
  int m_lat = 0;
  bit m_done = 0;
  bit m_in_es = 0;
  logic [3:0] m_sect = 0;
  bit m_rv = 0;
  logic [7:0] m_rd = 0;
  bit sus, res;
  logic [3:0] rsect;
  logic [7:0] mstat;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_lat = 0; m_done = 0; m_in_es = 0; m_sect = 0; m_rv = 0;
    end else begin
      sus = cmd_valid && cmd_data == 8'hB0;
      res = cmd_valid && cmd_data == 8'h30;
      mstat = {5'd0, m_in_es, (m_st == 3), (m_st == 1 || m_st == 2)};
      m_rv = rd_valid && (m_st == 0 || m_st == 3);
      if (m_rv) begin
        rsect = rd_addr[11:8];
        if (rd_asel) m_rd = (rd_addr[7:0] == 8'd0) ? MFR : DEV;
        else if ((m_st == 3 && rsect == m_sect) || (es_active && rsect == es_sect)) m_rd = mstat;
        else m_rd = arr_fn(rd_addr);
      end
      m_done = 0;
      case (m_st)
        0: if (pgm_start && pgm_len != 0) begin
             m_st = 1; m_rem = int'(pgm_len); m_sect = pgm_sect; m_in_es = es_active;
           end
        1: if (sus) begin m_st = 2; m_lat = LAT; end
           else begin
             if (m_rem == 1) begin m_st = 0; m_done = 1; m_in_es = 0; end
             m_rem--;
           end
        2: if (m_lat <= 1) m_st = 3; else m_lat--;
        default: if (res) m_st = 1;
      endcase
    end
  end

  // Compare a quarter period before each rising edge
  always begin
    @(negedge clk); #5;
    if (!rst_n) begin
      chk("R10 busy in reset", 32'(pgm_busy), 0);
      chk("R10 held in reset", 32'(pgm_held), 0);
      chk("R10 status in reset", 32'(status_byte), 0);
    end else begin
      chk("R2 eng_run", 32'(eng_run), 32'(m_st == 1 && !(cmd_valid && cmd_data == 8'hB0)));
      chk("R2 pgm_done", 32'(pgm_done), 32'(m_done));
      chk("R3 pgm_busy", 32'(pgm_busy), 32'(m_st == 1 || m_st == 2));
      chk("R3 pgm_held", 32'(pgm_held), 32'(m_st == 3));
      chk("R8 status_byte", 32'(status_byte),
          32'({m_in_es, (m_st == 3), (m_st == 1 || m_st == 2)}));
      chk("R9 rd_ready", 32'(rd_ready), 32'(m_st == 0 || m_st == 3));
      chk("R9 rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) chk("R5 rsp_data", 32'(rsp_data), 32'(m_rd));
      if (eng_run) run_cnt++;
    end
  end

  task automatic send_cmd(input logic [7:0] d);
    @(negedge clk); cmd_valid = 1'b1; cmd_data = d;
    @(negedge clk); cmd_valid = 1'b0; cmd_data = 8'h00;
  endtask

  task automatic start_pgm(input int len, input logic [3:0] s);
    @(negedge clk); pgm_start = 1'b1; pgm_len = 16'(len); pgm_sect = s;
    @(negedge clk); pgm_start = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, input logic asel, output logic [7:0] d);
    @(negedge clk); rd_valid = 1'b1; rd_addr = a; rd_asel = asel;
    for (int i = 0; i < 4000; i++) begin
      #5;
      if (rd_ready) break;
      @(negedge clk);
    end
    @(negedge clk); rd_valid = 1'b0; rd_asel = 1'b0;
    #5 d = rsp_data;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #5;
      if (pgm_done) break;
    end
  endtask

  task automatic wait_held();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #5;
      if (pgm_held) break;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    chk("R1 rd_ready", 32'(rd_ready), 1);
    chk("R1 cmd_ready", 32'(cmd_ready), 1);
    chk("R1 busy", 32'(pgm_busy), 0);
    chk("R1 status", 32'(status_byte), 0);

    // Plain run, with a misplaced resume and a second start while running
    run_cnt = 0;
    start_pgm(20, 4'd3);
    send_cmd(8'h30);
    start_pgm(5, 4'd1);
    wait_done();
    chk("R11 R2 run length", 32'(run_cnt), 20);
    start_pgm(0, 4'd2);
    @(negedge clk); #5;
    chk("R2 zero length dropped", 32'(pgm_busy), 0);

    // Suspend, settle, held reads, resume
    run_cnt = 0;
    start_pgm(40, 4'd5);
    repeat (9) @(negedge clk);
    send_cmd(8'hB0);
    send_cmd(8'hB0);
    send_cmd(8'h30);
    repeat (LAT - 5) @(negedge clk);
    #5 chk("R3 not yet held", 32'(pgm_held), 0);
    @(negedge clk); #5 chk("R3 held after settle", 32'(pgm_held), 1);
    do_read(12'h5_20, 1'b0, d); chk("R5 held sector gives status", 32'(d), 32'h02);
    do_read(12'h2_10, 1'b0, d); chk("R5 other sector gives array", 32'(d), 32'(arr_fn(12'h2_10)));
    do_read(12'h9_00, 1'b1, d); chk("R6 maker code", 32'(d), 32'(MFR));
    do_read(12'h9_03, 1'b1, d); chk("R6 device code", 32'(d), 32'(DEV));
    send_cmd(8'hB0);
    send_cmd(8'hF0);
    #5 chk("R8 ignored words keep held", 32'(status_byte), 32'h02);
    send_cmd(8'h30);
    wait_done();
    chk("R4 total run after resume", 32'(run_cnt), 40);

    // Suspend on the final run cycle
    run_cnt = 0;
    start_pgm(4, 4'd6);
    repeat (2) @(negedge clk);
    send_cmd(8'hB0);
    wait_held();
    send_cmd(8'h30);
    wait_done();
    chk("R4 last-cycle suspend", 32'(run_cnt), 4);

    // Program nested in an erase hold, then reset while held
    es_active = 1'b1; es_sect = 4'd7;
    start_pgm(30, 4'd2);
    repeat (4) @(negedge clk);
    send_cmd(8'hB0);
    wait_held();
    do_read(12'h7_44, 1'b0, d); chk("R7 erase-held sector", 32'(d), 32'h06);
    do_read(12'h2_01, 1'b0, d); chk("R7 program sector", 32'(d), 32'h06);
    do_read(12'h4_55, 1'b0, d); chk("R7 other sector", 32'(d), 32'(arr_fn(12'h4_55)));
    @(negedge clk); rst_n = 1'b0;
    #5;
    chk("R10 held cleared", 32'(pgm_held), 0);
    chk("R10 status cleared", 32'(status_byte), 0);
    @(negedge clk); rst_n = 1'b1; es_active = 1'b0;
    @(negedge clk); #5;
    chk("R10 idle after reset", 32'(rd_ready), 1);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule